// File: doc/BRIEF.md
# Temperature Threshold Interrupt Generator

This block watches the digital temperature readings of three sensor channels and compares each one against its own high limit and a lower hysteresis limit. From those comparisons it drives one active-low alert pin and a set of per-channel status bits. The readings are 8-bit two's-complement values. A reading counts as above the high limit only when it is strictly greater than that limit. It counts as below the hysteresis limit only when it is strictly less than that limit.

Each channel runs in one of two modes. In comparator mode, which is the reset default, the channel holds its alert condition from the moment its reading goes above the high limit until the reading drops below the hysteresis limit. In event mode, the channel raises an event once when the reading crosses above the high limit and once when it later falls below the hysteresis limit. The event stays latched until software has read the status of every enabled channel.

A pin-function control picks between the management-interrupt use of the pin and the over-temperature use. The registered select is brought out so that the surrounding pin multiplexer can follow it.

Top module: `thr_alert_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `status_o` is all zero, `alert_n_o` is 1 and `pin_fn_o` is 0.
- R2: In comparator mode (`mode_i` bit = 0) an enabled channel drives `alert_n_o` low in the cycle after its reading becomes greater than its high limit. A reading equal to the high limit does not assert it. The pin stays low while the reading is at or above the hysteresis limit, and it returns high in the cycle after the reading becomes less than the hysteresis limit.
- R3: All comparisons are signed. A high limit of -5 is exceeded by -4 and not by -6. A hysteresis limit of -20 is undercut by -21.
- R4: In event mode (`mode_i` bit = 1), a reading crossing above the high limit sets that channel's status bit, and the channel holds `alert_n_o` low until the read-clear completes.
- R5: After an above-limit event has been cleared, a reading that stays above the high limit raises no new event until it has first dropped below the hysteresis limit.
- R6: A channel whose reading was above the high limit and then becomes less than the hysteresis limit raises a second event, which sets its status bit.
- R7: Pending status is cleared only once a read strobe (`rd_strobe_i` bit k for channel k) has been seen for every enabled channel. The strobes may arrive in different cycles. A partial set of reads leaves every status bit set.
- R8: If a channel raises an event in the same cycle as the final read, that channel's status bit stays set while the other bits clear.
- R9: A channel with its `ch_en_i` bit at 0 never sets its status bit, never affects `alert_n_o`, and needs no read for the clear.
- R10: `pin_fn_o` follows `pin_fn_i` one cycle later (1 = management interrupt, 0 = over-temperature). While `pin_fn_o` is 1, `alert_n_o` is held at 1.
- R11: In comparator mode, the threshold crossings still set the status bit, and it remains set until the read-clear, even after the reading has left the alert band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_i | input | 24 | Readings; channel k in bits [8k+7:8k], signed |
| hi_lim_i | input | 24 | High limits, same packing |
| hyst_lim_i | input | 24 | Hysteresis limits, same packing |
| ch_en_i | input | 3 | Per-channel alert enable |
| mode_i | input | 3 | Per-channel mode: 0 comparator, 1 event |
| pin_fn_i | input | 1 | Pin function: 1 management interrupt, 0 over-temperature |
| rd_strobe_i | input | 3 | Per-channel status-read strobe |
| alert_n_o | output | 1 | Active-low alert |
| status_o | output | 3 | Sticky per-channel event status |
| pin_fn_o | output | 1 | Registered pin-function select |

## Verification
Two functions of this block can fall in the same cycle: a fresh threshold crossing on one channel and the final status read that completes the clear. The bench sets this up by leaving one channel pending and reading the other channels one at a time. It then issues the last read strobe in the same cycle that it drops a second channel's reading below its hysteresis limit. The result is judged one cycle later: only the newly crossing channel may still show status, and the alert must remain low.

// File: rtl/thr_alert_pkg.sv
// Shared types for the temperature threshold alert block.
// Assumes: all temperature values are two's-complement.
package thr_alert_pkg;

    // Per-channel alert behaviour selected by a mode bit.
    typedef enum logic {
        ALERT_CMP = 1'b0,
        ALERT_EVT = 1'b1
    } alert_mode_e;

    // Two-bit tracking state of one channel.
    typedef struct packed {
        logic above;  // reading seen above high limit, not yet below hysteresis
        logic pend;   // sticky event status
    } chan_state_t;

endpackage

// File: rtl/thr_chan_track.sv
// One channel of threshold tracking.
// Detects upward crossings of the high limit and downward crossings of the
// hysteresis limit, keeps a sticky status bit and presents this channel's
// alert condition according to its mode.
// Assumes: hyst_i is not above hi_i; clr_i is a single-cycle pulse.
module thr_chan_track
    import thr_alert_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              mode_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] hi_i,
    input  logic [TEMP_W-1:0] hyst_i,
    input  logic              clr_i,
    output logic              evt_o,
    output logic              status_o,
    output logic              cond_o
);

    chan_state_t st_q;
    logic        over_hi;
    logic        under_hyst;
    alert_mode_e mode;

    assign mode = alert_mode_e'(mode_i);

    // Purpose: signed threshold comparisons.
    always_comb begin
        over_hi    = $signed(temp_i) > $signed(hi_i);
        under_hyst = $signed(temp_i) < $signed(hyst_i);
    end

    // Purpose: a crossing event in either direction, gated by the enable.
    assign evt_o = en_i & ((!st_q.above & over_hi) | (st_q.above & under_hyst));

    // Purpose: update the tracking flag and the sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            st_q <= '0;
        end else begin
            st_q.above <= st_q.above ? !under_hyst : over_hi;
            st_q.pend  <= (st_q.pend & !clr_i) | evt_o;
        end
    end

    assign status_o = st_q.pend;

    // Purpose: alert condition, the band flag or the latched event.
    assign cond_o = en_i & ((mode == ALERT_EVT) ? st_q.pend : st_q.above);

endmodule

// File: rtl/thr_read_clear.sv
// Read-clear tracker.
// Collects status-read strobes per enabled channel and issues one clear pulse
// once every enabled channel has been read. Any new event restarts the tally.
// Assumes: rd_i bits are one-cycle strobes from the host decode.
module thr_read_clear #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] rd_i,
    input  logic              any_evt_i,
    output logic              clr_o
);

    logic [NUM_CH-1:0] seen_q;

    // Purpose: the clear fires when every enabled channel is covered.
    assign clr_o = &(seen_q | rd_i | ~en_i);

    // Purpose: accumulate reads and restart after a clear or a new event.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_o || any_evt_i) begin
            seen_q <= '0;
        end else begin
            seen_q <= (seen_q | rd_i) & en_i;
        end
    end

endmodule

// File: rtl/thr_alert_top.sv
// Temperature threshold alert top.
// Instantiates one tracker per channel and a shared read-clear tracker, and
// merges the channel conditions into one active-low alert pin.
// Assumes: channel k occupies bits [k*TEMP_W +: TEMP_W] of each packed bus.
module thr_alert_top #(
    parameter int NUM_CH = 3,
    parameter int TEMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*TEMP_W-1:0] temp_i,
    input  logic [NUM_CH*TEMP_W-1:0] hi_lim_i,
    input  logic [NUM_CH*TEMP_W-1:0] hyst_lim_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    input  logic [NUM_CH-1:0]        mode_i,
    input  logic                     pin_fn_i,
    input  logic [NUM_CH-1:0]        rd_strobe_i,
    output logic                     alert_n_o,
    output logic [NUM_CH-1:0]        status_o,
    output logic                     pin_fn_o
);

    logic [NUM_CH-1:0] evt;
    logic [NUM_CH-1:0] cond;
    logic              clr;
    logic              pin_fn_q;

    // Purpose: one tracker per sensor channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        thr_chan_track #(.TEMP_W(TEMP_W)) trk_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ch_en_i[k]),
            .mode_i   (mode_i[k]),
            .temp_i   (temp_i[k*TEMP_W +: TEMP_W]),
            .hi_i     (hi_lim_i[k*TEMP_W +: TEMP_W]),
            .hyst_i   (hyst_lim_i[k*TEMP_W +: TEMP_W]),
            .clr_i    (clr),
            .evt_o    (evt[k]),
            .status_o (status_o[k]),
            .cond_o   (cond[k])
        );
    end

    thr_read_clear #(.NUM_CH(NUM_CH)) rdc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ch_en_i),
        .rd_i      (rd_strobe_i),
        .any_evt_i (|evt),
        .clr_o     (clr)
    );

    // Purpose: register the pin-function select.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_fn_q <= 1'b0;
        else        pin_fn_q <= pin_fn_i;
    end

    assign pin_fn_o = pin_fn_q;

    // Purpose: active-low OR of conditions, idle in management-interrupt use.
    assign alert_n_o = pin_fn_q | ~(|cond);

endmodule

// File: rtl/thr_alert_chk.sv
// Assertion checker for thr_alert_top, attached by bind below.
module thr_alert_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_en_i,
    input logic [NUM_CH-1:0] rd_strobe_i,
    input logic              alert_n_o,
    input logic [NUM_CH-1:0] status_o,
    input logic              pin_fn_o
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && alert_n_o && !pin_fn_o))
        else $error("a_r1_reset_quiet");

    a_r7_partial_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ch_en_i) != '0 && rd_strobe_i == '0 && $stable(ch_en_i))
        |=> (status_o != '0))
        else $error("a_r7_partial_keeps");

    a_r9_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(ch_en_i)) == '0))
        else $error("a_r9_disabled_clear");

    a_r10_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fn_o |-> alert_n_o)
        else $error("a_r10_pin_idle");

endmodule

bind thr_alert_top thr_alert_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en_i     (ch_en_i),
    .rd_strobe_i (rd_strobe_i),
    .alert_n_o   (alert_n_o),
    .status_o    (status_o),
    .pin_fn_o    (pin_fn_o)
);

// File: tb/thr_alert_top_tb_top.sv
module thr_alert_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int TW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*TW-1:0] temp = '0;
    logic [NCH*TW-1:0] hi = '0;
    logic [NCH*TW-1:0] hyst = '0;
    logic [NCH-1:0]    en = '0;
    logic [NCH-1:0]    mode = '0;
    logic              pin_fn = 1'b0;
    logic [NCH-1:0]    rd = '0;
    logic              alert_n;
    logic [NCH-1:0]    status;
    logic              pin_fn_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_alert_top #(.NUM_CH(NCH), .TEMP_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_i(temp), .hi_lim_i(hi),
        .hyst_lim_i(hyst), .ch_en_i(en), .mode_i(mode), .pin_fn_i(pin_fn),
        .rd_strobe_i(rd), .alert_n_o(alert_n), .status_o(status),
        .pin_fn_o(pin_fn_q)
    );

    // Vector: [11] mode, [10:3] temp ch0, [2] read ch0, [1] alert_n, [0] status0.
    // Channel 0 only, hi=50, hyst=40.
    localparam logic [11:0] VEC [0:14] = '{
        {1'b0, 8'd30,  1'b1, 1'b1, 1'b0},  // R2 below all
        {1'b0, 8'd50,  1'b0, 1'b1, 1'b0},  // R2 equal high: not above
        {1'b0, 8'd51,  1'b0, 1'b0, 1'b1},  // R2 R11 rise
        {1'b0, 8'd45,  1'b1, 1'b0, 1'b0},  // R11 cleared, band held
        {1'b0, 8'd40,  1'b0, 1'b0, 1'b0},  // R2 equal hysteresis: not below
        {1'b0, 8'd39,  1'b0, 1'b1, 1'b1},  // R2 R11 fall
        {1'b0, 8'd20,  1'b1, 1'b1, 1'b0},  // R11 clear
        {1'b1, 8'd60,  1'b0, 1'b0, 1'b1},  // R4 rise event
        {1'b1, 8'd70,  1'b0, 1'b0, 1'b1},  // R4 held
        {1'b1, 8'd70,  1'b1, 1'b1, 1'b0},  // R4 clear
        {1'b1, 8'd80,  1'b0, 1'b1, 1'b0},  // R5 no refire
        {1'b1, 8'd30,  1'b0, 1'b0, 1'b1},  // R6 fall event
        {1'b1, 8'd30,  1'b0, 1'b0, 1'b1},  // R6 held
        {1'b1, 8'd30,  1'b1, 1'b1, 1'b0},  // R6 clear
        {1'b1, 8'hF6,  1'b0, 1'b1, 1'b0}   // R5 stays quiet below
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; temp = '0; hi = '0; hyst = '0; en = '0;
        mode = '0; pin_fn = 1'b0; rd = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic set_ch(input int k, input logic [7:0] t,
                          input logic [7:0] h, input logic [7:0] y);
        temp[k*TW +: TW] = t;
        hi[k*TW +: TW]   = h;
        hyst[k*TW +: TW] = y;
    endtask

    initial begin
        step(); step();
        // R1 reset state
        chk("R1 status", {5'd0, status}, 8'd0);
        chk("R1 alert_n", {7'd0, alert_n}, 8'd1);
        chk("R1 pin_fn", {7'd0, pin_fn_q}, 8'd0);
        rst_n = 1'b1;

        // Table walk on channel 0
        en = 3'b001;
        set_ch(0, 8'd0, 8'd50, 8'd40);
        for (int i = 0; i < 15; i++) begin
            mode[0]  = VEC[i][11];
            temp[7:0] = VEC[i][10:3];
            rd       = {2'b00, VEC[i][2]};
            step();
            rd = '0;
            chk($sformatf("R2/R4/R5/R6/R11 vec%0d alert_n", i), {7'd0, alert_n}, {7'd0, VEC[i][1]});
            chk($sformatf("R2/R4/R5/R6/R11 vec%0d status", i), {7'd0, status[0]}, {7'd0, VEC[i][0]});
        end

        // R3 signed limits: hi=-5, hyst=-20
        do_reset();
        en = 3'b001;
        set_ch(0, 8'hFC, 8'hFB, 8'hEC); step();
        chk("R3 -4 above -5", {7'd0, alert_n}, 8'd0);
        temp[7:0] = 8'hFA; step();
        chk("R3 -6 held", {7'd0, alert_n}, 8'd0);
        temp[7:0] = 8'hEB; step();
        chk("R3 -21 below -20", {7'd0, alert_n}, 8'd1);

        // R7 reads across cycles
        do_reset();
        en = 3'b111; mode = 3'b111;
        for (int k = 0; k < NCH; k++) set_ch(k, 8'd60, 8'd50, 8'd40);
        step();
        chk("R7 all pending", {5'd0, status}, 8'h07);
        rd = 3'b001; step(); rd = '0;
        chk("R7 partial a", {5'd0, status}, 8'h07);
        rd = 3'b010; step(); rd = '0;
        chk("R7 partial b", {5'd0, status}, 8'h07);
        rd = 3'b100; step(); rd = '0;
        chk("R7 cleared", {5'd0, status}, 8'h00);
        chk("R7 alert released", {7'd0, alert_n}, 8'd1);

        // R8 event in the cycle of the final read
        temp[0*TW +: TW] = 8'd30; step();
        chk("R8 setup", {5'd0, status}, 8'h01);
        rd = 3'b001; step();
        rd = 3'b010; step();
        rd = 3'b100; temp[1*TW +: TW] = 8'd30; step(); rd = '0;
        chk("R8 new event kept", {5'd0, status}, 8'h02);
        chk("R8 alert held", {7'd0, alert_n}, 8'd0);

        // R9 disabled channel
        do_reset();
        en = 3'b011; mode = 3'b111;
        set_ch(0, 8'd0, 8'd50, 8'd40);
        set_ch(1, 8'd0, 8'd50, 8'd40);
        set_ch(2, 8'd90, 8'd50, 8'd40);
        step();
        chk("R9 disabled no status", {5'd0, status}, 8'h00);
        chk("R9 disabled no alert", {7'd0, alert_n}, 8'd1);
        temp[7:0] = 8'd60; step();
        chk("R9 enabled fires", {5'd0, status}, 8'h01);
        rd = 3'b011; step(); rd = '0;
        chk("R9 clear without ch2 read", {5'd0, status}, 8'h00);

        // R10 pin function
        do_reset();
        en = 3'b001;
        set_ch(0, 8'd60, 8'd50, 8'd40); step();
        chk("R10 over-temp alert", {7'd0, alert_n}, 8'd0);
        pin_fn = 1'b1; step();
        chk("R10 select follows", {7'd0, pin_fn_q}, 8'd1);
        chk("R10 alert idle", {7'd0, alert_n}, 8'd1);
        pin_fn = 1'b0; step();
        chk("R10 alert back", {7'd0, alert_n}, 8'd0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule